// File: doc/BRIEF.md
# Reservation Station Bank with Tag-Match Wakeup

This block holds the waiting operations for one class of functional unit (an add/subtract unit here) in an out-of-order core. Each cycle the front end may hand the bank one operation. For each of its two sources the operation carries either a value or the tag of the station that will produce that value. The bank places the operation in the lowest-numbered free entry. When no entry is free, the issue request is refused, which is the structural stall.

Waiting entries snoop a shared result bus. That bus carries a value and the 4-bit tag of its producer. An entry whose source tag equals the bus tag takes the value and clears that tag. A tag of zero always means the value is present, so no separate ready bit exists. Among entries whose two tags are zero, the oldest one is offered to the unit, one per cycle, while the unit signals it can accept. The operation leaves together with the entry's own fixed tag, `TAG_BASE + index`. The entry stays occupied until the unit broadcasts a result carrying that tag.

Each entry runs a four-state machine:
- `ST_IDLE` means the entry is free.
- `ST_WAIT` means the entry is busy and at least one source tag is nonzero.
- `ST_READY` means both source tags are zero and the entry has not been dispatched.
- `ST_EXEC` means the entry has been dispatched and is waiting for its own result.

The transitions are:
- `load` moves IDLE to READY or WAIT, depending on the tags after any capture at issue.
- `wake` moves WAIT to READY when the last missing operand is captured.
- `grant` moves READY to EXEC.
- `retire` moves EXEC to IDLE when the bus carries the entry's own tag.

Top module: `rsv_bank`

## Requirements
- R1: After reset every entry is free, so `iss_ready` is 1 and `disp_valid` is 0.
- R2: An operation issued with both source tags zero is offered on the dispatch port in the next cycle, provided the unit is free and no older ready entry exists. The offered operands are the issued values.
- R3: A source with a nonzero tag blocks dispatch until the bus carries that tag. The bus value then replaces the operand, and the entry can dispatch from the following cycle.
- R4: If the bus carries a source's tag in the same cycle that the operation issues, the value is captured at issue and the entry does not wait.
- R5: When all `N` entries are busy, `iss_ready` is 0 and an asserted `iss_valid` changes nothing in the bank.
- R6: Among ready entries the one issued earliest is dispatched first, regardless of its index.
- R7: At most one operation is offered per cycle. Nothing is offered while `unit_free` is 0.
- R8: A dispatched entry becomes free in the cycle after the bus carries its own tag. Other bus tags do not free it.
- R9: `disp_op` repeats the issued operation code: 0 is add and 1 is subtract.
- R10: An issued operation takes the lowest-indexed free entry, and `disp_tag` equals `TAG_BASE` plus that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 1 | Operation code (0 add, 1 subtract) |
| iss_vj | input | DATA_W | First source value |
| iss_tj | input | TAG_W | First source producer tag (0 = value present) |
| iss_vk | input | DATA_W | Second source value |
| iss_tk | input | TAG_W | Second source producer tag (0 = value present) |
| iss_ready | output | 1 | A free entry exists; the issue is accepted |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Tag of the producer on the bus |
| bus_value | input | DATA_W | Result value on the bus |
| unit_free | input | 1 | Functional unit accepts an operation this cycle |
| disp_valid | output | 1 | An operation is offered to the unit |
| disp_op | output | 1 | Operation code of the offered operation |
| disp_a | output | DATA_W | First operand |
| disp_b | output | DATA_W | Second operand |
| disp_tag | output | TAG_W | Tag of the dispatching entry |

## Verification
Four properties are checked every cycle:
- at most one grant is given;
- nothing is dispatched while the unit is busy;
- no entry is granted while it still holds a nonzero source tag;
- an executing entry whose own tag appears on the bus is free in the next cycle.

Two more are also checked every cycle: a refused issue coincides with a full bank, and the dispatched tag stays in the bank's range. Oldest-first order, capture at issue time, values forwarded from a dependent producer, and the exact dispatch cycle can only be shown by the bench's scenarios. The bench compares those against its reference model on every clock.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READY,
        ST_EXEC
    } ent_state_t;

endpackage

// File: rtl/rsv_entry.sv
module rsv_entry
    import rsv_pkg::*;
#(
    parameter int               DATA_W  = 64,
    parameter int               TAG_W   = 4,
    parameter logic [TAG_W-1:0] OWN_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_op,
    input  logic [DATA_W-1:0] in_vj,
    input  logic [TAG_W-1:0]  in_qj,
    input  logic [DATA_W-1:0] in_vk,
    input  logic [TAG_W-1:0]  in_qk,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              grant,
    output logic              is_free,
    output logic              is_ready,
    output logic              is_exec,
    output logic              op_o,
    output logic [DATA_W-1:0] vj_o,
    output logic [DATA_W-1:0] vk_o,
    output logic [TAG_W-1:0]  qj_o,
    output logic [TAG_W-1:0]  qk_o
);

    ent_state_t        state, state_n;
    logic              op_q, op_n;
    logic [DATA_W-1:0] vj_q, vj_n, vk_q, vk_n;
    logic [TAG_W-1:0]  qj_q, qj_n, qk_q, qk_n;

    logic in_hit_j, in_hit_k, hit_j, hit_k, own_hit;

    // bus matches against the incoming operation and against held tags
    assign in_hit_j = bus_valid && (in_qj != '0) && (bus_tag == in_qj);
    assign in_hit_k = bus_valid && (in_qk != '0) && (bus_tag == in_qk);
    assign hit_j    = bus_valid && (qj_q  != '0) && (bus_tag == qj_q);
    assign hit_k    = bus_valid && (qk_q  != '0) && (bus_tag == qk_q);
    assign own_hit  = bus_valid && (bus_tag == OWN_TAG);

    always_comb begin
        state_n = state;
        op_n    = op_q;
        vj_n    = vj_q;
        vk_n    = vk_q;
        qj_n    = qj_q;
        qk_n    = qk_q;
        unique case (state)
            ST_IDLE: begin
                if (load) begin
                    op_n    = in_op;
                    vj_n    = in_hit_j ? bus_value : in_vj;
                    qj_n    = in_hit_j ? '0 : in_qj;
                    vk_n    = in_hit_k ? bus_value : in_vk;
                    qk_n    = in_hit_k ? '0 : in_qk;
                    state_n = (qj_n == '0 && qk_n == '0) ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (hit_j) begin
                    vj_n = bus_value;
                    qj_n = '0;
                end
                if (hit_k) begin
                    vk_n = bus_value;
                    qk_n = '0;
                end
                if (qj_n == '0 && qk_n == '0) state_n = ST_READY;
            end
            ST_READY: begin
                if (grant) state_n = ST_EXEC;
            end
            ST_EXEC: begin
                if (own_hit) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= 1'b0;
            vj_q  <= '0;
            vk_q  <= '0;
            qj_q  <= '0;
            qk_q  <= '0;
        end else begin
            state <= state_n;
            op_q  <= op_n;
            vj_q  <= vj_n;
            vk_q  <= vk_n;
            qj_q  <= qj_n;
            qk_q  <= qk_n;
        end
    end

    always_comb begin
        is_free  = (state == ST_IDLE);
        is_ready = (state == ST_READY);
        is_exec  = (state == ST_EXEC);
        op_o     = op_q;
        vj_o     = vj_q;
        vk_o     = vk_q;
        qj_o     = qj_q;
        qk_o     = qk_q;
    end

endmodule

// File: rtl/rsv_pick.sv
module rsv_pick #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] free,
    input  logic [N-1:0] ready,
    input  logic         accept,
    input  logic         unit_free,
    output logic [N-1:0] load_sel,
    output logic [N-1:0] grant,
    output logic         any_free
);

    // older[i][j] set: entry i was issued before entry j
    logic [N-1:0] older [N];
    logic [N-1:0] wins;

    always_comb begin
        load_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) load_sel = '0;
            if (free[i]) load_sel[i] = 1'b1;
        end
        any_free = |free;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            wins[i] = ready[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && older[j][i]) wins[i] = 1'b0;
            end
        end
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (wins[i] && unit_free) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older[i] <= '0;
        end else if (accept) begin
            for (int k = 0; k < N; k++) begin
                if (load_sel[k]) begin
                    for (int j = 0; j < N; j++) begin
                        older[k][j] <= 1'b0;
                        if (j != k) older[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rsv_bank.sv
module rsv_bank #(
    parameter int N        = 3,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic              iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_tj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_tk,
    output logic              iss_ready,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              unit_free,
    output logic              disp_valid,
    output logic              disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag
);

    logic [N-1:0]             ent_free, ent_ready, ent_exec;
    logic [N-1:0]             load_sel, grant, ent_op;
    logic [N-1:0][DATA_W-1:0] ent_vj, ent_vk;
    logic [N-1:0][TAG_W-1:0]  ent_qj, ent_qk;
    logic                     any_free, accept;

    assign accept    = iss_valid && any_free;
    assign iss_ready = any_free;

    rsv_pick #(.N(N)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .free      (ent_free),
        .ready     (ent_ready),
        .accept    (accept),
        .unit_free (unit_free),
        .load_sel  (load_sel),
        .grant     (grant),
        .any_free  (any_free)
    );

    for (genvar g = 0; g < N; g++) begin : g_ent
        rsv_entry #(
            .DATA_W  (DATA_W),
            .TAG_W   (TAG_W),
            .OWN_TAG (TAG_W'(TAG_BASE + g))
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (accept && load_sel[g]),
            .in_op     (iss_op),
            .in_vj     (iss_vj),
            .in_qj     (iss_tj),
            .in_vk     (iss_vk),
            .in_qk     (iss_tk),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .grant     (grant[g]),
            .is_free   (ent_free[g]),
            .is_ready  (ent_ready[g]),
            .is_exec   (ent_exec[g]),
            .op_o      (ent_op[g]),
            .vj_o      (ent_vj[g]),
            .vk_o      (ent_vk[g]),
            .qj_o      (ent_qj[g]),
            .qk_o      (ent_qk[g])
        );
    end

    always_comb begin
        disp_valid = |grant;
        disp_op    = 1'b0;
        disp_a     = '0;
        disp_b     = '0;
        disp_tag   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                disp_op  = ent_op[i];
                disp_a   = ent_vj[i];
                disp_b   = ent_vk[i];
                disp_tag = TAG_W'(TAG_BASE + i);
            end
        end
    end

endmodule

// File: rtl/rsv_bank_chk.sv
module rsv_bank_chk #(
    parameter int N        = 3,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    iss_ready,
    input logic                    bus_valid,
    input logic [TAG_W-1:0]        bus_tag,
    input logic                    unit_free,
    input logic                    disp_valid,
    input logic [TAG_W-1:0]        disp_tag,
    input logic [N-1:0]            ent_free,
    input logic [N-1:0]            ent_exec,
    input logic [N-1:0][TAG_W-1:0] ent_qj,
    input logic [N-1:0][TAG_W-1:0] ent_qk,
    input logic [N-1:0]            grant
);

    localparam logic [TAG_W-1:0] FIRST_TAG = TAG_W'(TAG_BASE);
    localparam logic [TAG_W-1:0] LAST_TAG  = TAG_W'(TAG_BASE + N - 1);

    logic [N-1:0] tags_zero, rel_mask;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tags_zero[i] = (ent_qj[i] == '0) && (ent_qk[i] == '0);
            rel_mask[i]  = ent_exec[i] && bus_valid && (bus_tag == TAG_W'(TAG_BASE + i));
        end
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7
    hold_when_unit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_free |-> !disp_valid);

    // R3
    grant_needs_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~tags_zero) == '0);

    // R8
    free_on_own_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mask != '0) |=> ((ent_free & $past(rel_mask)) == $past(rel_mask)));

    // R5
    full_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (ent_free == '0));

    // R10
    disp_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_tag >= FIRST_TAG && disp_tag <= LAST_TAG));

endmodule

bind rsv_bank rsv_bank_chk #(.N(N), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_ready  (iss_ready),
    .bus_valid  (bus_valid),
    .bus_tag    (bus_tag),
    .unit_free  (unit_free),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag),
    .ent_free   (ent_free),
    .ent_exec   (ent_exec),
    .ent_qj     (ent_qj),
    .ent_qk     (ent_qk),
    .grant      (grant)
);

// File: tb/rsv_bank_test.sv
`timescale 1ns/1ps
module rsv_bank_test;

    localparam int N   = 3;
    localparam int DW  = 64;
    localparam int TW  = 4;
    localparam int TB  = 1;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          iss_valid, iss_op, iss_ready;
    logic [DW-1:0] iss_vj, iss_vk;
    logic [TW-1:0] iss_tj, iss_tk;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_value;
    logic          unit_free, disp_valid, disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic [TW-1:0] disp_tag;

    always #4 clk = ~clk;

    rsv_bank #(.N(N), .DATA_W(DW), .TAG_W(TW), .TAG_BASE(TB)) uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_tj(iss_tj),
        .iss_vk(iss_vk), .iss_tk(iss_tk), .iss_ready(iss_ready),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .unit_free(unit_free), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
    );

    int  vecs = 0, miss = 0, cyc = 0;
    bit  done = 0;

    // reference model state
    bit            m_busy [N];
    bit            m_exec [N];
    bit            m_op   [N];
    logic [DW-1:0] m_vj   [N];
    logic [DW-1:0] m_vk   [N];
    logic [TW-1:0] m_qj   [N];
    logic [TW-1:0] m_qk   [N];
    int            m_seq  [N];
    int            seq_ctr = 0;

    int            p_due [$];
    logic [DW-1:0] p_val [$];
    logic [TW-1:0] p_tag [$];
    logic [TW-1:0] x_tag [$];
    logic [DW-1:0] x_val [$];

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic step(string req, bit iv, bit op, logic [DW-1:0] vj, logic [TW-1:0] tj,
                        logic [DW-1:0] vk, logic [TW-1:0] tk, bit uf);
        bit            bv, rdy, dv;
        logic [TW-1:0] bt;
        logic [DW-1:0] bval, res;
        int            slot, sel;
        iss_valid = iv; iss_op = op; iss_vj = vj; iss_tj = tj;
        iss_vk = vk; iss_tk = tk; unit_free = uf;
        if (p_due.size() > 0 && p_due[0] == cyc) begin
            void'(p_due.pop_front());
            bv = 1; bt = p_tag.pop_front(); bval = p_val.pop_front();
        end else if (x_tag.size() > 0) begin
            bv = 1; bt = x_tag.pop_front(); bval = x_val.pop_front();
        end else begin
            bv = 0; bt = '0; bval = '0;
        end
        bus_valid = bv; bus_tag = bt; bus_value = bval;
        #1;
        slot = -1; sel = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_busy[i]) slot = i;
        rdy = (slot >= 0);
        for (int i = 0; i < N; i++)
            if (m_busy[i] && !m_exec[i] && m_qj[i] == 0 && m_qk[i] == 0)
                if (sel < 0 || m_seq[i] < m_seq[sel]) sel = i;
        dv = uf && (sel >= 0);
        chk(req, "iss_ready", DW'(iss_ready), DW'(rdy));
        chk(req, "disp_valid", DW'(disp_valid), DW'(dv));
        if (dv) begin
            chk(req, "disp_tag", DW'(disp_tag), DW'(TB + sel));
            chk(req, "disp_a", disp_a, m_vj[sel]);
            chk(req, "disp_b", disp_b, m_vk[sel]);
            chk(req, "disp_op", DW'(disp_op), DW'(m_op[sel]));
        end
        // next state of the model
        if (dv) begin
            res = m_op[sel] ? m_vj[sel] - m_vk[sel] : m_vj[sel] + m_vk[sel];
            p_due.push_back(cyc + LAT); p_val.push_back(res); p_tag.push_back(TW'(TB + sel));
        end
        for (int i = 0; i < N; i++) begin
            if (m_busy[i] && bv) begin
                if (m_qj[i] != 0 && m_qj[i] == bt) begin m_vj[i] = bval; m_qj[i] = 0; end
                if (m_qk[i] != 0 && m_qk[i] == bt) begin m_vk[i] = bval; m_qk[i] = 0; end
                if (m_exec[i] && bt == TW'(TB + i)) begin m_busy[i] = 0; m_exec[i] = 0; end
            end
        end
        if (dv) m_exec[sel] = 1;
        if (iv && rdy) begin
            m_busy[slot] = 1; m_exec[slot] = 0; m_op[slot] = op;
            if (bv && tj != 0 && tj == bt) begin m_vj[slot] = bval; m_qj[slot] = 0; end
            else begin m_vj[slot] = vj; m_qj[slot] = tj; end
            if (bv && tk != 0 && tk == bt) begin m_vk[slot] = bval; m_qk[slot] = 0; end
            else begin m_vk[slot] = vk; m_qk[slot] = tk; end
            m_seq[slot] = seq_ctr++;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(string req, int n, bit uf);
        for (int i = 0; i < n; i++) step(req, 0, 0, '0, '0, '0, '0, uf);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        rst_n = 0; iss_valid = 0; iss_op = 0; iss_vj = '0; iss_vk = '0;
        iss_tj = '0; iss_tk = '0; bus_valid = 0; bus_tag = '0; bus_value = '0; unit_free = 0;
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_exec[i] = 0; m_op[i] = 0;
            m_vj[i] = '0; m_vk[i] = '0; m_qj[i] = '0; m_qk[i] = '0; m_seq[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        idle("R1", 2, 1);
        // R2, R9, R10: ready operands, add then subtract; R8 frees after own result
        step("R2", 1, 0, 64'd10, 0, 64'd3, 0, 1);
        step("R9", 1, 1, 64'd10, 0, 64'd3, 0, 1);
        idle("R8", 8, 1);
        // R3: dependent on a bank producer and on an external producer
        step("R3", 1, 0, 64'd5, 0, 64'd6, 0, 1);
        step("R3", 1, 1, 64'd0, 4'd1, 64'd100, 0, 1);
        step("R3", 1, 0, 64'd0, 4'd9, 64'd0, 4'd9, 1);
        idle("R3", 3, 1);
        x_tag.push_back(4'd9); x_val.push_back(64'd77);
        idle("R3", 8, 1);
        // R4: bus carries the source tag in the issue cycle
        x_tag.push_back(4'd10); x_val.push_back(64'h55);
        step("R4", 1, 0, 64'd0, 4'd10, 64'd1, 0, 1);
        idle("R4", 6, 1);
        // R5, R7, R10: unit held busy, four issues with three entries
        step("R10", 1, 0, 64'd1, 0, 64'd1, 0, 0);
        step("R10", 1, 1, 64'd2, 0, 64'd1, 0, 0);
        step("R5", 1, 0, 64'd3, 0, 64'd1, 0, 0);
        step("R5", 1, 1, 64'd4, 0, 64'd1, 0, 0);
        idle("R7", 3, 0);
        idle("R7", 12, 1);
        // R6: older entry at a higher index goes first
        step("R6", 1, 0, 64'd1, 0, 64'd2, 0, 1);
        step("R6", 1, 0, 64'd0, 4'd13, 64'd4, 0, 1);
        idle("R6", 5, 1);
        step("R6", 1, 1, 64'd9, 0, 64'd8, 0, 0);
        x_tag.push_back(4'd13); x_val.push_back(64'd20);
        idle("R6", 2, 0);
        idle("R6", 8, 1);
        // R3, R7: mixed traffic
        lf = 16'hACE1;
        for (int t = 0; t < 400; t++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[10] && lf[11]) begin
                x_tag.push_back({1'b1, lf[14:12]}); x_val.push_back(64'(lf) * 64'd3);
            end
            step("R3", lf[0], lf[1], 64'(lf), lf[2] ? {1'b1, lf[5:3]} : 4'd0,
                 64'(lf ^ 16'h0F0F), lf[6] ? {1'b1, lf[9:7]} : 4'd0, lf[8] | lf[9]);
        end
        for (int t = 8; t < 16; t++) begin
            x_tag.push_back(TW'(t)); x_val.push_back(64'(t));
        end
        idle("R8", 30, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule